// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This passive observer sits on the command bus of a four-bank, 32-bit-wide synchronous DRAM. It samples the four active-low strobes (chip select, row strobe, column strobe, write enable) together with the bank address and the auto-precharge/all-banks address bit on each rising clock edge. It then decides whether the command just registered is allowed by the device's current state.

It tracks two kinds of state. The first is a device-wide lockout that starts with a refresh, a mode-register load or a precharge of all banks, and runs for the matching timing parameter. The second is a per-bank record of whether each bank is open, idle or still precharging. A command that breaks a rule produces a one-cycle violation pulse with a 3-bit cause code. The illegal command does not change the tracked state, so a single error does not set off a cascade of false reports. Timing limits are parameters counted in clock cycles.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Commands decode from {cs_n,ras_n,cas_n,we_n}. cs_n high is an inhibit and 0111 is a no-op. Neither is ever a violation. The other codes are 0011 activate, 0101 read, 0100 write, 0110 burst stop, 0010 precharge (a10 high means all banks), 0001 auto refresh and 0000 mode-register load.
- R2: A legal auto refresh raises `lock_busy` from the next cycle for T_RC-1 cycles. The first non-no-op command accepted without a lockout report is the one registered T_RC edges after the refresh.
- R3: A legal mode-register load locks the device the same way for T_MRD cycles.
- R4: A legal precharge with a10 high closes every bank and locks the device for T_RP cycles.
- R5: A command other than inhibit or no-op during a lockout is reported with code 1. This check takes priority over every other check.
- R6: Activate to a bank that is open or still precharging is reported with code 2. Activate to an idle bank sets that bank's `bank_open` bit.
- R7: A read or write to a bank that is not open is reported with code 3.
- R8: An auto refresh or mode-register load while any bank is open or precharging is reported with code 4.
- R9: A single-bank precharge (a10 low) closes an open bank, and the bank stays busy for T_RP cycles. A precharge aimed at a bank that is still precharging is reported with code 5. A precharge of all banks while any bank is still precharging is also reported with code 5. A single-bank precharge to an idle bank does nothing.
- R10: A burst stop is legal only while a read or write burst is live. Otherwise it is reported with code 6. A burst is live from a legal read or write until a burst stop, or until a precharge that reaches the bank of that burst.
- R11: A command reported as a violation changes no bank, lockout or burst state.
- R12: Reset clears all banks to idle, clears the lockout and clears the violation outputs.
- R13: `viol` pulses high for exactly the cycle after the offending edge, with a non-zero `viol_code`. Both are zero in every cycle without a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BW | Bank address |
| a10 | input | 1 | All-banks select for precharge |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Cause of the violation, 0 when none |
| lock_busy | output | 1 | Device-wide lockout in progress |
| bank_open | output | NB | One bit per bank, set while the bank is active |

## Verification
The bench targets the last cycle of each lockout. A counter that is off by one either flags the legal command issued T edges after the lock began or lets through a command one edge too early. It also probes the priority of the lockout code over the bank checks, since a design with the wrong order would report code 2 or 3 during a refresh. It checks that an illegal activate, refresh or precharge leaves state untouched; a design that applied them would report false errors later in the sequence. Finally, it asserts reset in the middle of a refresh lockout: a design that does not clear its counter would reject the activate that follows.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int NB    = 4,
  parameter int T_RC  = 6,
  parameter int T_RP  = 3,
  parameter int T_MRD = 2,
  localparam int BW   = $clog2(NB),
  localparam int TMAX = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                      : ((T_RP > T_MRD) ? T_RP : T_MRD),
  localparam int CW   = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic [BW-1:0] ba,
  input  logic          a10,
  output logic          viol,
  output logic [2:0]    viol_code,
  output logic          lock_busy,
  output logic [NB-1:0] bank_open
);
  logic [CW-1:0] lk;
  logic [CW-1:0] pc [NB];
  logic [NB-1:0] bank_pre;
  logic          burst_live;
  logic [BW-1:0] burst_ba;
  logic [2:0]    op, code_n;

  assign op        = {ras_n, cas_n, we_n};
  wire   is_nop    = cs_n | (op == 3'b111);
  assign lock_busy = (lk != '0);
  wire   all_idle  = (bank_open == '0) && (bank_pre == '0);
  wire   ok        = !is_nop && (code_n == 3'd0);

  always_comb begin
    code_n = 3'd0;
    if (!is_nop) begin
      if (lock_busy) code_n = 3'd1;
      else begin
        case (op)
          3'b011:         if (bank_open[ba] || bank_pre[ba]) code_n = 3'd2;
          3'b101, 3'b100: if (!bank_open[ba]) code_n = 3'd3;
          3'b110:         if (!burst_live) code_n = 3'd6;
          3'b010:         if (a10 ? (bank_pre != '0) : bank_pre[ba]) code_n = 3'd5;
          3'b001, 3'b000: if (!all_idle) code_n = 3'd4;
          default:        code_n = 3'd0;
        endcase
      end
    end
  end

  wire pre_hit_any = ok && (op == 3'b010);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    wire act_me = ok && (op == 3'b011) && (ba == BW'(b));
    wire pre_me = pre_hit_any && (a10 || (ba == BW'(b)));
    assign bank_pre[b] = (pc[b] != '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_open[b] <= 1'b0;
        pc[b]        <= '0;
      end else begin
        if (pre_me && !a10 && bank_open[b]) pc[b] <= CW'(T_RP - 1);
        else if (pc[b] != '0)               pc[b] <= pc[b] - 1'b1;
        if (act_me)      bank_open[b] <= 1'b1;
        else if (pre_me) bank_open[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk         <= '0;
      burst_live <= 1'b0;
      burst_ba   <= '0;
      viol       <= 1'b0;
      viol_code  <= 3'd0;
    end else begin
      viol      <= (code_n != 3'd0);
      viol_code <= code_n;
      if (ok && op == 3'b001)              lk <= CW'(T_RC - 1);
      else if (ok && op == 3'b000)         lk <= CW'(T_MRD - 1);
      else if (ok && op == 3'b010 && a10)  lk <= CW'(T_RP - 1);
      else if (lk != '0)                   lk <= lk - 1'b1;
      if (ok && (op == 3'b101 || op == 3'b100)) begin
        burst_live <= 1'b1;
        burst_ba   <= ba;
      end else if (ok && op == 3'b110) begin
        burst_live <= 1'b0;
      end else if (pre_hit_any && (a10 || ba == burst_ba)) begin
        burst_live <= 1'b0;
      end
    end
  end
endmodule

module sdram_cmd_monitor_chk #(
  parameter int NB = 4,
  parameter int T_RC = 6,
  localparam int BW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          ras_n,
  input logic          cas_n,
  input logic          we_n,
  input logic [BW-1:0] ba,
  input logic          viol,
  input logic [2:0]    viol_code,
  input logic          lock_busy,
  input logic [NB-1:0] bank_open,
  input logic [NB-1:0] bank_pre
);
  wire [2:0] op  = {ras_n, cas_n, we_n};
  wire       nop = cs_n || (op == 3'b111);

  p_nop_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    nop |=> !viol);

  p_ref_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RC > 1) && !lock_busy && !cs_n && op == 3'b001 && bank_open == '0 && bank_pre == '0
    |=> lock_busy);

  p_lock_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_busy && !nop |=> viol && viol_code == 3'd1);

  p_act_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_busy && !cs_n && op == 3'b011 && !bank_open[ba] && !bank_pre[ba]
    |=> bank_open[$past(ba)] && !viol);

  p_rw_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_busy && !cs_n && (op == 3'b101 || op == 3'b100) && !bank_open[ba]
    |=> viol && viol_code == 3'd3);

  p_pulse_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
    viol == (viol_code != 3'd0));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NB(NB), .T_RC(T_RC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .viol(viol), .viol_code(viol_code),
  .lock_busy(lock_busy), .bank_open(bank_open), .bank_pre(bank_pre));

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic viol, lock_busy;
  logic [2:0] viol_code;
  logic [3:0] bank_open;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_monitor #(.NB(4), .T_RC(6), .T_RP(3), .T_MRD(2)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .viol(viol), .viol_code(viol_code),
    .lock_busy(lock_busy), .bank_open(bank_open));

  localparam logic [3:0] NOP = 4'b0111, INH = 4'b1111, ACT = 4'b0011, RD = 4'b0101,
    WR = 4'b0100, BT = 4'b0110, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  // tag, cmd, ba, a10, exp viol, exp code, exp bank_open, exp lock_busy
  localparam int N = 26;
  localparam logic [39:0] VEC [N] = '{
    {"R3 ", LMR, 2'd0, 1'b0, 1'b0, 3'd0, 4'b0000, 1'b1},
    {"R5 ", ACT, 2'd0, 1'b0, 1'b1, 3'd1, 4'b0000, 1'b0},
    {"R6 ", ACT, 2'd0, 1'b0, 1'b0, 3'd0, 4'b0001, 1'b0},
    {"R7 ", RD,  2'd1, 1'b0, 1'b1, 3'd3, 4'b0001, 1'b0},
    {"R10", RD,  2'd0, 1'b0, 1'b0, 3'd0, 4'b0001, 1'b0},
    {"R10", BT,  2'd0, 1'b0, 1'b0, 3'd0, 4'b0001, 1'b0},
    {"R10", BT,  2'd0, 1'b0, 1'b1, 3'd6, 4'b0001, 1'b0},
    {"R6 ", ACT, 2'd0, 1'b0, 1'b1, 3'd2, 4'b0001, 1'b0},
    {"R8 ", REF, 2'd0, 1'b0, 1'b1, 3'd4, 4'b0001, 1'b0},
    {"R11", PRE, 2'd0, 1'b0, 1'b0, 3'd0, 4'b0000, 1'b0},
    {"R9 ", ACT, 2'd0, 1'b0, 1'b1, 3'd2, 4'b0000, 1'b0},
    {"R9 ", PRE, 2'd0, 1'b1, 1'b1, 3'd5, 4'b0000, 1'b0},
    {"R2 ", REF, 2'd0, 1'b0, 1'b0, 3'd0, 4'b0000, 1'b1},
    {"R5 ", WR,  2'd2, 1'b0, 1'b1, 3'd1, 4'b0000, 1'b1},
    {"R1 ", NOP, 2'd0, 1'b0, 1'b0, 3'd0, 4'b0000, 1'b1},
    {"R1 ", NOP, 2'd3, 1'b1, 1'b0, 3'd0, 4'b0000, 1'b1},
    {"R1 ", INH, 2'd2, 1'b0, 1'b0, 3'd0, 4'b0000, 1'b1},
    {"R2 ", ACT, 2'd2, 1'b0, 1'b1, 3'd1, 4'b0000, 1'b0},
    {"R2 ", ACT, 2'd2, 1'b0, 1'b0, 3'd0, 4'b0100, 1'b0},
    {"R13", WR,  2'd2, 1'b0, 1'b0, 3'd0, 4'b0100, 1'b0},
    {"R6 ", ACT, 2'd3, 1'b0, 1'b0, 3'd0, 4'b1100, 1'b0},
    {"R4 ", PRE, 2'd1, 1'b1, 1'b0, 3'd0, 4'b0000, 1'b1},
    {"R4 ", RD,  2'd3, 1'b0, 1'b1, 3'd1, 4'b0000, 1'b1},
    {"R4 ", NOP, 2'd0, 1'b0, 1'b0, 3'd0, 4'b0000, 1'b0},
    {"R7 ", RD,  2'd3, 1'b0, 1'b1, 3'd3, 4'b0000, 1'b0},
    {"R10", BT,  2'd0, 1'b0, 1'b1, 3'd6, 4'b0000, 1'b0}
  };

  task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic a);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    a10 = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [23:0] tag, input logic [8:0] exp);
    logic [8:0] got;
    got = {viol, viol_code, bank_open, lock_busy};
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got viol/code/open/busy=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog: got no end, expected end of run");
    finish_run();
  end

  initial begin
    @(negedge clk);
    check("R12", 9'b0_000_0000_0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      drive(VEC[i][15:12], VEC[i][11:10], VEC[i][9]);
      check(VEC[i][39:16], VEC[i][8:0]);
    end
    // R8: mode load with a bank open; R11: state unchanged afterwards
    drive(ACT, 2'd1, 1'b0);
    check("R6 ", 9'b0_000_0010_0);
    drive(LMR, 2'd0, 1'b0);
    check("R8 ", 9'b1_100_0010_0);
    drive(NOP, 2'd0, 1'b0);
    check("R11", 9'b0_000_0010_0);
    // R9: single precharge on an idle bank is harmless
    drive(PRE, 2'd3, 1'b0);
    check("R9 ", 9'b0_000_0010_0);
    drive(PRE, 2'd1, 1'b0);
    check("R9 ", 9'b0_000_0000_0);
    drive(PRE, 2'd1, 1'b0);
    check("R9 ", 9'b1_101_0000_0);
    drive(NOP, 2'd0, 1'b0);
    drive(ACT, 2'd1, 1'b0);
    check("R9 ", 9'b0_000_0010_0);
    drive(PRE, 2'd1, 1'b1);
    drive(NOP, 2'd0, 1'b0);
    drive(NOP, 2'd0, 1'b0);
    // R12: reset in the middle of a refresh lockout
    drive(REF, 2'd0, 1'b0);
    check("R2 ", 9'b0_000_0000_1);
    {cs_n, ras_n, cas_n, we_n} = NOP;
    rst_n = 1'b0;
    @(negedge clk);
    check("R12", 9'b0_000_0000_0);
    rst_n = 1'b1;
    drive(ACT, 2'd2, 1'b0);
    check("R12", 9'b0_000_0100_0);
    drive(NOP, 2'd0, 1'b0);
    check("R13", 9'b0_000_0100_0);
    finish_run();
  end
endmodule